// File: doc/BRIEF.md
# Two-Parallel Delayed-LMS Adaptive FIR Filter

This block is an 8-tap adaptive FIR filter that consumes two input samples and two reference (desired) samples on every clock. On every clock it also returns two filter outputs and two error values. At equal clock frequency it therefore carries twice the sample rate of a one-sample-per-clock filter. The even-indexed sample x(2n) arrives on `x_even` and the odd-indexed sample x(2n+1) arrives on `x_odd` in the same cycle.

Filtering uses the two-parallel fast FIR split. The coefficients are divided into an even half H0 (w0, w2, w4, w6) and an odd half H1 (w1, w3, w5, w7). Three half-length subfilters compute H0·X0, H1·X1 and (H0+H1)·(X0+X1), and a post-add stage rebuilds the even and odd outputs. The coefficients adapt by a delayed LMS rule. Each tap's gradient combines both errors of a pair. The step size is a power-of-two shift, and a parameter sets the number of pipeline stages on the gradient path.

Arithmetic is 16-bit two's complement. Coefficients are Q2.14 values: 14 fraction bits.

Top module: `pdlms_filter`

## Requirements
- R1: A synchronous active-high reset clears the sample history, the pipeline and all coefficients. In the first cycle after a reset edge, all four outputs read zero.
- R2: One sample pair is accepted at every clock edge. The outputs present after edge t belong to the pair captured at edge t−2.
- R3: y_even for pair n equals sat(floor(S/2^14)), where S = Σi w(2i)·x(2n−2i) + Σi w(2i+1)·x(2n−2i−1). The even weights in S are those held after edge t−2, and the odd weights are those held after edge t−3.
- R4: y_odd for pair n equals sat(floor(S/2^14)), where S = Σi w(2i)·x(2n+1−2i) + Σi w(2i+1)·x(2n−2i). All weights in S are those held after edge t−2. The combined coefficients used by the third subfilter change on the same edge as the weights they are built from.
- R5: Output scaling is an arithmetic right shift by 14 bits (rounding toward minus infinity), followed by saturation to the range [−32768, 32767].
- R6: e_even = sat(d(2n) − y_even) and e_odd = sat(d(2n+1) − y_odd). Both use the same saturation range as R5.
- R7: Each weight updates as w_k ← sat(w_k + floor(g_k/2^MU_SHIFT)), with MU_SHIFT = 16 by default. The errors of pair n feed g: g(2i) = e_even·x(2n−2i) + e_odd·x(2n+1−2i), and g(2i+1) = e_even·x(2n−2i−1) + e_odd·x(2n−2i). With GRAD_STAGES = G (default 1), errors held after edge t change the weights at edge t+1+G.
- R8: If every desired sample since reset is zero, the weights stay zero. Outputs and errors then stay zero for any input samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample pair per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_even | input | 16 | Input sample x(2n), signed |
| x_odd | input | 16 | Input sample x(2n+1), signed |
| d_even | input | 16 | Desired sample d(2n), signed |
| d_odd | input | 16 | Desired sample d(2n+1), signed |
| y_even | output | 16 | Filter output y(2n), signed |
| y_odd | output | 16 | Filter output y(2n+1), signed |
| e_even | output | 16 | Error d(2n) − y(2n), signed |
| e_odd | output | 16 | Error d(2n+1) − y(2n+1), signed |

## Verification
A weight update and the post-add that rebuilds y_even can land on the same clock edge. When that happens, the delayed H1·X1 term still carries products made with the previous coefficient set, while the H0·X0 term already uses the new one. Continuous adaptation with large, full-scale inputs forces this overlap on nearly every edge. The bench judges it against a model that keeps the weight vector of every edge and mixes the generations exactly as R3 states. Saturated outputs and errors are provoked by extreme directed patterns in the same runs.

// File: rtl/pdlms_pkg.sv
package pdlms_pkg;

    localparam int DATA_W = 16;
    localparam int COEF_W = DATA_W;
    localparam int ACC_W  = 40;
    localparam int WIDE_W = 48;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        sample_t ev;
        sample_t od;
    } pair_t;

    localparam longint SMAX = (longint'(1) <<< (DATA_W - 1)) - 1;
    localparam longint SMIN = -(longint'(1) <<< (DATA_W - 1));

    function automatic sample_t clip_w(input wide_t v);
        if (v > wide_t'(SMAX))
            return sample_t'(SMAX);
        else if (v < wide_t'(SMIN))
            return sample_t'(SMIN);
        else
            return v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/pdlms_subfilter.sv
module pdlms_subfilter
    import pdlms_pkg::*;
#(
    parameter int N  = 4,
    parameter int XW = 16,
    parameter int HW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [XW-1:0] xv [N],
    input  logic signed [HW-1:0] hv [N],
    output acc_t                 acc
);

    acc_t sum_c;
    logic all_zero;

    always_comb begin
        sum_c    = '0;
        all_zero = 1'b1;
        for (int i = 0; i < N; i++) begin
            sum_c = sum_c + acc_t'(xv[i]) * acc_t'(hv[i]);
            if (xv[i] != '0)
                all_zero = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else
            acc <= sum_c;
    end

    AST_ZERO_TAPS_ZERO_SUM: assert property (@(posedge clk) disable iff (rst)
        all_zero |=> (acc == '0)); // R8

endmodule

// File: rtl/pdlms_recombine.sv
module pdlms_recombine
    import pdlms_pkg::*;
#(
    parameter int FRAC = 14
) (
    input  logic  clk,
    input  logic  rst,
    input  acc_t  s_even,
    input  acc_t  s_odd,
    input  acc_t  s_cross,
    input  pair_t d_al,
    output pair_t y_q,
    output pair_t e_q
);

    acc_t    s_odd_d;
    acc_t    ye_full;
    acc_t    yo_full;
    pair_t   y_c;
    pair_t   e_c;

    always_comb begin
        ye_full = s_even + s_odd_d;
        yo_full = s_cross - s_even - s_odd;
        y_c.ev  = clip_w(wide_t'(ye_full >>> FRAC));
        y_c.od  = clip_w(wide_t'(yo_full >>> FRAC));
        e_c.ev  = clip_w(wide_t'(d_al.ev) - wide_t'(y_c.ev));
        e_c.od  = clip_w(wide_t'(d_al.od) - wide_t'(y_c.od));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_odd_d <= '0;
            y_q     <= '0;
            e_q     <= '0;
        end else begin
            s_odd_d <= s_odd;
            y_q     <= y_c;
            e_q     <= e_c;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (y_q == '0 && e_q == '0)); // R1

endmodule

// File: rtl/pdlms_adapt.sv
module pdlms_adapt
    import pdlms_pkg::*;
#(
    parameter int TAPS        = 8,
    parameter int MU_SHIFT    = 16,
    parameter int GRAD_STAGES = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  pair_t                 err,
    input  sample_t               xa_g [TAPS/2],
    input  sample_t               xb_g [TAPS/2+1],
    output coef_t                 w_even [TAPS/2],
    output coef_t                 w_odd  [TAPS/2],
    output logic signed [COEF_W:0] w_sum [TAPS/2]
);

    localparam int HALF = TAPS / 2;
    localparam int GW   = 2 * DATA_W + 1;

    logic signed [GW-1:0] g    [TAPS];
    logic signed [GW-1:0] gp   [GRAD_STAGES][TAPS];
    coef_t                w    [TAPS];
    coef_t                w_nx [TAPS];

    always_comb begin
        for (int i = 0; i < HALF; i++) begin
            g[2*i]   = GW'(err.ev) * GW'(xa_g[i])   + GW'(err.od) * GW'(xb_g[i]);
            g[2*i+1] = GW'(err.ev) * GW'(xb_g[i+1]) + GW'(err.od) * GW'(xa_g[i]);
        end
        for (int k = 0; k < TAPS; k++)
            w_nx[k] = clip_w(wide_t'(w[k]) + wide_t'(gp[GRAD_STAGES-1][k] >>> MU_SHIFT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < GRAD_STAGES; s++)
                for (int k = 0; k < TAPS; k++)
                    gp[s][k] <= '0;
            for (int k = 0; k < TAPS; k++)
                w[k] <= '0;
            for (int i = 0; i < HALF; i++)
                w_sum[i] <= '0;
        end else begin
            for (int k = 0; k < TAPS; k++)
                gp[0][k] <= g[k];
            for (int s = 1; s < GRAD_STAGES; s++)
                for (int k = 0; k < TAPS; k++)
                    gp[s][k] <= gp[s-1][k];
            for (int k = 0; k < TAPS; k++)
                w[k] <= w_nx[k];
            for (int i = 0; i < HALF; i++)
                w_sum[i] <= (COEF_W+1)'(w_nx[2*i]) + (COEF_W+1)'(w_nx[2*i+1]);
        end
    end

    for (genvar i = 0; i < HALF; i++) begin : g_split
        assign w_even[i] = w[2*i];
        assign w_odd[i]  = w[2*i+1];

        AST_SUM_TRACKS: assert property (@(posedge clk) disable iff (rst)
            w_sum[i] == (COEF_W+1)'(w[2*i]) + (COEF_W+1)'(w[2*i+1])); // R4
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_hold
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
            (gp[GRAD_STAGES-1][k] == '0) |=> $stable(w[k])); // R7
    end

endmodule

// File: rtl/pdlms_filter.sv
module pdlms_filter
    import pdlms_pkg::*;
#(
    parameter int TAPS        = 8,
    parameter int MU_SHIFT    = 16,
    parameter int GRAD_STAGES = 1,
    parameter int FRAC        = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] x_even,
    input  logic signed [DATA_W-1:0] x_odd,
    input  logic signed [DATA_W-1:0] d_even,
    input  logic signed [DATA_W-1:0] d_odd,
    output logic signed [DATA_W-1:0] y_even,
    output logic signed [DATA_W-1:0] y_odd,
    output logic signed [DATA_W-1:0] e_even,
    output logic signed [DATA_W-1:0] e_odd
);

    localparam int HALF  = TAPS / 2;
    localparam int XA_D  = HALF + 2;
    localparam int XB_D  = HALF + 3;
    localparam int SUM_W = DATA_W + 1;

    sample_t                 xa [XA_D];
    sample_t                 xb [XB_D];
    pair_t                   d_q;
    pair_t                   d_al;

    sample_t                 xa_sub [HALF];
    sample_t                 xb_sub [HALF];
    logic signed [SUM_W-1:0] xs_sub [HALF];
    sample_t                 xa_g   [HALF];
    sample_t                 xb_g   [HALF+1];

    coef_t                   w_even [HALF];
    coef_t                   w_odd  [HALF];
    logic signed [COEF_W:0]  w_sum  [HALF];

    acc_t                    s_even;
    acc_t                    s_odd;
    acc_t                    s_cross;
    pair_t                   y_q;
    pair_t                   e_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < XA_D; i++) xa[i] <= '0;
            for (int i = 0; i < XB_D; i++) xb[i] <= '0;
            d_q  <= '0;
            d_al <= '0;
        end else begin
            xa[0] <= x_even;
            xb[0] <= x_odd;
            for (int i = 1; i < XA_D; i++) xa[i] <= xa[i-1];
            for (int i = 1; i < XB_D; i++) xb[i] <= xb[i-1];
            d_q.ev <= d_even;
            d_q.od <= d_odd;
            d_al   <= d_q;
        end
    end

    for (genvar i = 0; i < HALF; i++) begin : g_win
        assign xa_sub[i] = xa[i];
        assign xb_sub[i] = xb[i];
        assign xs_sub[i] = SUM_W'(xa[i]) + SUM_W'(xb[i]);
        assign xa_g[i]   = xa[i+2];
    end
    for (genvar i = 0; i < HALF + 1; i++) begin : g_winb
        assign xb_g[i] = xb[i+2];
    end

    pdlms_subfilter #(.N(HALF), .XW(DATA_W), .HW(COEF_W)) u_sub_even (
        .clk (clk), .rst (rst), .xv (xa_sub), .hv (w_even), .acc (s_even)
    );

    pdlms_subfilter #(.N(HALF), .XW(DATA_W), .HW(COEF_W)) u_sub_odd (
        .clk (clk), .rst (rst), .xv (xb_sub), .hv (w_odd), .acc (s_odd)
    );

    pdlms_subfilter #(.N(HALF), .XW(SUM_W), .HW(COEF_W+1)) u_sub_cross (
        .clk (clk), .rst (rst), .xv (xs_sub), .hv (w_sum), .acc (s_cross)
    );

    pdlms_recombine #(.FRAC(FRAC)) u_recomb (
        .clk     (clk),
        .rst     (rst),
        .s_even  (s_even),
        .s_odd   (s_odd),
        .s_cross (s_cross),
        .d_al    (d_al),
        .y_q     (y_q),
        .e_q     (e_q)
    );

    pdlms_adapt #(.TAPS(TAPS), .MU_SHIFT(MU_SHIFT), .GRAD_STAGES(GRAD_STAGES)) u_adapt (
        .clk    (clk),
        .rst    (rst),
        .err    (e_q),
        .xa_g   (xa_g),
        .xb_g   (xb_g),
        .w_even (w_even),
        .w_odd  (w_odd),
        .w_sum  (w_sum)
    );

    assign y_even = y_q.ev;
    assign y_odd  = y_q.od;
    assign e_even = e_q.ev;
    assign e_odd  = e_q.od;

endmodule

// File: tb/pdlms_filter_tb.sv
module pdlms_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TAPS       = 8;
    localparam int MU         = 16;
    localparam int ADAPT_G    = 1;
    localparam int NMAX       = 700;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [15:0] x_even = '0, x_odd = '0, d_even = '0, d_odd = '0;
    logic signed [15:0] y_even, y_odd, e_even, e_odd;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    longint x0m [NMAX];
    longint x1m [NMAX];
    longint d0m [NMAX];
    longint d1m [NMAX];
    longint wm  [NMAX][TAPS];
    longint y0m [NMAX];
    longint y1m [NMAX];
    longint e0m [NMAX];
    longint e1m [NMAX];

    longint hT [TAPS] = '{3000, -2000, 1500, 800, -600, 400, -200, 100};

    always #(CLK_PERIOD/2) clk = ~clk;

    pdlms_filter #(.TAPS(TAPS), .MU_SHIFT(MU), .GRAD_STAGES(ADAPT_G)) dut_i (
        .clk (clk), .rst (rst),
        .x_even (x_even), .x_odd (x_odd), .d_even (d_even), .d_odd (d_odd),
        .y_even (y_even), .y_odd (y_odd), .e_even (e_even), .e_odd (e_odd)
    );

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint xv0(input int p);
        return (p < 0) ? 0 : x0m[p];
    endfunction
    function automatic longint xv1(input int p);
        return (p < 0) ? 0 : x1m[p];
    endfunction
    function automatic longint dv0(input int p);
        return (p < 0) ? 0 : d0m[p];
    endfunction
    function automatic longint dv1(input int p);
        return (p < 0) ? 0 : d1m[p];
    endfunction
    function automatic longint wv(input int t, input int k);
        return (t < 0) ? 0 : wm[t][k];
    endfunction
    function automatic longint xs(input int m);
        if (m < 0) return 0;
        return (m % 2 == 0) ? x0m[m/2] : x1m[m/2];
    endfunction

    // Reference: direct-form sums with a per-edge weight history (R3, R4, R5, R6, R7)
    task automatic model_step(input int t);
        int te;
        int p;
        longint g;
        longint a0;
        longint a1;
        te = t - 1 - ADAPT_G;
        for (int k = 0; k < TAPS; k++) begin
            g = 0;
            if (te >= 0) begin
                p = te - 2;
                if (k % 2 == 0)
                    g = e0m[te] * xv0(p - k/2) + e1m[te] * xv1(p - k/2);
                else
                    g = e0m[te] * xv1(p - 1 - k/2) + e1m[te] * xv0(p - k/2);
            end
            wm[t][k] = sat16(wv(t-1, k) + (g >>> MU));
        end
        p  = t - 2;
        a0 = 0;
        a1 = 0;
        for (int i = 0; i < TAPS/2; i++) begin
            a0 += wv(t-2, 2*i) * xv0(p-i) + wv(t-3, 2*i+1) * xv1(p-1-i);
            a1 += wv(t-2, 2*i) * xv1(p-i) + wv(t-2, 2*i+1) * xv0(p-i);
        end
        y0m[t] = sat16(a0 >>> 14);
        y1m[t] = sat16(a1 >>> 14);
        e0m[t] = sat16(dv0(p) - y0m[t]);
        e1m[t] = sat16(dv1(p) - y1m[t]);
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint rnd_full();
        return longint'($signed(16'($urandom)));
    endfunction

    task automatic run_mode(input int mode, input int ncyc, input string tag);
        longint acc;
        rst = 1'b1;
        x_even = '0; x_odd = '0; d_even = '0; d_odd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "y_even after reset", longint'(y_even), 0);
        chk("R1", "y_odd after reset",  longint'(y_odd),  0);
        chk("R1", "e_even after reset", longint'(e_even), 0);
        chk("R1", "e_odd after reset",  longint'(e_odd),  0);
        rst = 1'b0;
        for (int t = 0; t < ncyc; t++) begin
            case (mode)
                0: begin
                    x0m[t] = rnd_full(); x1m[t] = rnd_full();
                    d0m[t] = 0; d1m[t] = 0;
                end
                1: begin
                    x0m[t] = longint'($urandom % 4096) - 2048;
                    x1m[t] = longint'($urandom % 4096) - 2048;
                    acc = 0;
                    for (int k = 0; k < TAPS; k++) acc += hT[k] * xs(2*t - k);
                    d0m[t] = sat16(acc >>> 14);
                    acc = 0;
                    for (int k = 0; k < TAPS; k++) acc += hT[k] * xs(2*t + 1 - k);
                    d1m[t] = sat16(acc >>> 14);
                end
                2: begin
                    x0m[t] = rnd_full(); x1m[t] = rnd_full();
                    d0m[t] = rnd_full(); d1m[t] = rnd_full();
                end
                default: begin
                    x0m[t] = (t % 2 == 0) ? 32767 : -32768;
                    x1m[t] = (t % 3 == 0) ? -32768 : 32767;
                    d0m[t] = (t < 40) ? 32767 : -32768;
                    d1m[t] = (t < 40) ? -32768 : 32767;
                end
            endcase
            x_even = 16'(x0m[t]); x_odd = 16'(x1m[t]);
            d_even = 16'(d0m[t]); d_odd = 16'(d1m[t]);
            model_step(t);
            @(posedge clk);
            @(negedge clk);
            chk({"R3 ", tag}, "y_even", longint'(y_even), y0m[t]);
            chk({"R4 ", tag}, "y_odd",  longint'(y_odd),  y1m[t]);
            chk({"R6 ", tag}, "e_even", longint'(e_even), e0m[t]);
            chk({"R6 ", tag}, "e_odd",  longint'(e_odd),  e1m[t]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_mode(0, 200, "R8");
        run_mode(1, 600, "R2 R7");
        run_mode(2, 400, "R5 R7");
        run_mode(3, 120, "R5");
        run_mode(1, 200, "R2 R7");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule